// File: doc/BRIEF.md
# Dual-Channel Down-Counting Event Timer

This peripheral holds two independent down-counters behind a small 32-bit register bus. Each channel has a control word, an interval and a readable count. A channel counts down once per prescaled tick. When it is enabled and at zero, the next tick is an expiry. An expiry sets the channel's status bit. A periodic channel then reloads its interval and keeps running. A single-shot channel stops at zero and clears its own enable.

A common setup loads one channel with all ones and leaves it running as a time base. Elapsed ticks are then the bitwise inverse of its count. The other channel produces periodic or single-shot events. The interrupt line is the OR, over all channels, of each status bit gated by its enable bit. Status bits are cleared by writing ones to them.

Reads are registered. A read address presented in one cycle returns its data in the next cycle. Two interval values follow from the expiry rule. An interval of N gives N+1 ticks from a load to the first expiry. Every later period also takes N+1 ticks.

Top module: `dual_countdown_timer`

## Requirements
- R1: While reset is asserted, and after it, every register reads zero and `irq_out` is low.
- R2: Control word layout: bit 0 enable, bit 1 reload, bits 6:4 prescaler select, bit 7 single-shot (1) or periodic (0). A write that changes this word shows its value on the next read. The reload bit always reads 0.
- R3: Register addresses: interrupt enable 0x00, interrupt status 0x04. Channel n uses 0x10+0x20·n for control, 0x14+0x20·n for interval and 0x1C+0x20·n for count. Bit n of the enable and status words belongs to channel n.
- R4: A control write with reload set copies the interval into the count. With enable also set, the count then drops by one on every tick.
- R5: With prescaler select s, a tick occurs once every 2^s clocks while the channel is enabled. The tick phase restarts on a reload.
- R6: In periodic mode, a tick at count zero sets the status bit and loads the interval back into the count. The enable bit stays set.
- R7: In single-shot mode, a tick at count zero sets the status bit and clears the enable bit. The count stays at zero.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_out` is a register that follows OR(status AND enable) with one clock of delay. A masked status bit keeps it low.
- R10: When enable is cleared, the count is frozen from the next clock on.
- R11: Writes to the count address have no effect on the count.
- R12: The channels count independently. A periodic channel loaded with all ones advances its elapsed value (the inverse of its count) by one per tick.
- R13: `reg_rdata` is registered. It returns the register at the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting and the bus both run on it |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counters and a 3-bit prescaler select. With these values both a time-base channel and an event channel are present at once. Prescaler select values 0, 2 and 7 are used. Select 2 makes the tick phase visible cycle by cycle, and select 7 exercises the widest field. Short intervals of 3 and 5 bring periodic wrap and single-shot expiry within a few dozen clocks. An all-ones interval checks the inverted time-base reading, without waiting for a full wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Bus map (byte addresses)
  localparam int IEN_ADDR  = 'h00;
  localparam int IST_ADDR  = 'h04;
  localparam int CH_BASE   = 'h10;
  localparam int CH_STRIDE = 'h20;
  localparam int OFS_CTRL  = 'h0;
  localparam int OFS_IVAL  = 'h4;
  localparam int OFS_CNT   = 'hC;

  // Control word bit positions
  localparam int CB_EN     = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_SEL_LO = 4;
  localparam int CB_ONE    = 7;

  typedef struct packed {
    logic       one;
    logic [2:0] sel;
    logic       reload;
    logic       en;
  } ctl_t;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i < int'(sel));
  end

  assign tick = run && (pcnt == mask);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) pcnt <= '0;
    else                                pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             en_in,
  input  logic             reload_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             one_in,
  input  logic             ival_wr,
  input  logic [CNT_W-1:0] ival_in,
  output logic             en,
  output logic             one,
  output logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] ival,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             expire
);
  tmr_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (en),
    .restart (ctl_wr && reload_in),
    .sel     (sel),
    .tick    (tick)
  );

  assign expire = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      one  <= 1'b0;
      sel  <= '0;
      ival <= '0;
      cnt  <= '0;
    end else begin
      if (tick) begin
        if (cnt == '0) begin
          if (one) en  <= 1'b0;
          else     cnt <= ival;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (ctl_wr) begin
        en  <= en_in;
        one <= one_in;
        sel <= sel_in;
        if (reload_in) cnt <= ival;
      end
      if (ival_wr) ival <= ival_in;
    end
  end
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  import tmr_pkg::*;

  function automatic logic [ADDR_W-1:0] ch_addr(int idx, int ofs);
    return ADDR_W'(CH_BASE + CH_STRIDE * idx + ofs);
  endfunction

  logic [NUM_CH-1:0]             ch_en, ch_one, ch_tick, ch_expire, ctl_wr, ival_wr;
  logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_ival, ch_cnt;
  logic [NUM_CH-1:0]             ien, ist, ist_clr;
  logic [DATA_W-1:0]             rd_mux, rdata_q;
  logic                          irq_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ctl_wr[g]  = reg_we && (reg_addr == ch_addr(g, OFS_CTRL));
    assign ival_wr[g] = reg_we && (reg_addr == ch_addr(g, OFS_IVAL));

    tmr_channel #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .ctl_wr    (ctl_wr[g]),
      .en_in     (reg_wdata[CB_EN]),
      .reload_in (reg_wdata[CB_RELOAD]),
      .sel_in    (reg_wdata[CB_SEL_LO +: SEL_W]),
      .one_in    (reg_wdata[CB_ONE]),
      .ival_wr   (ival_wr[g]),
      .ival_in   (reg_wdata[CNT_W-1:0]),
      .en        (ch_en[g]),
      .one       (ch_one[g]),
      .sel       (ch_sel[g]),
      .ival      (ch_ival[g]),
      .cnt       (ch_cnt[g]),
      .tick      (ch_tick[g]),
      .expire    (ch_expire[g])
    );
  end

  assign ist_clr = (reg_we && reg_addr == ADDR_W'(IST_ADDR)) ? reg_wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(IEN_ADDR)) rd_mux = DATA_W'(ien);
    if (reg_addr == ADDR_W'(IST_ADDR)) rd_mux = DATA_W'(ist);
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == ch_addr(i, OFS_CTRL))
        rd_mux = DATA_W'({ch_one[i], ch_sel[i], 3'b000, ch_en[i]});
      if (reg_addr == ch_addr(i, OFS_IVAL)) rd_mux = DATA_W'(ch_ival[i]);
      if (reg_addr == ch_addr(i, OFS_CNT))  rd_mux = DATA_W'(ch_cnt[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien     <= '0;
      ist     <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(IEN_ADDR)) ien <= reg_wdata[NUM_CH-1:0];
      ist     <= (ist & ~ist_clr) | ch_expire;
      rdata_q <= rd_mux;
      irq_q   <= |(ist & ien);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic [DATA_W-1:0]               reg_rdata,
  input logic                            irq_out,
  input logic [NUM_CH-1:0]               ch_en,
  input logic [NUM_CH-1:0]               ch_one,
  input logic [NUM_CH-1:0]               ch_tick,
  input logic [NUM_CH-1:0]               ch_expire,
  input logic [NUM_CH-1:0]               ctl_wr,
  input logic [NUM_CH-1:0][CNT_W-1:0]    ch_cnt,
  input logic [NUM_CH-1:0]               ien,
  input logic [NUM_CH-1:0]               ist
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_out && reg_rdata == '0)); // R1

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    ((ist & ien) == '0) |=> !irq_out); // R9

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    ((ist & ien) != '0) |=> irq_out); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_RELOAD_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == ADDR_W'(16 + 32 * g)) |=> !reg_rdata[1]); // R2

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      (!ch_en[g] && !ctl_wr[g]) |=> $stable(ch_cnt[g])); // R10

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
      (ch_en[g] && !ch_tick[g] && !ctl_wr[g]) |=> $stable(ch_cnt[g])); // R5

    AST_EXPIRY_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
      ch_expire[g] |=> ist[g]); // R6

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
      (ch_expire[g] && ch_one[g] && !ctl_wr[g]) |=> (!ch_en[g] && ch_cnt[g] == '0)); // R7
  end
endmodule

bind dual_countdown_timer tmr_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_tmr_checker (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .ch_en     (ch_en),
  .ch_one    (ch_one),
  .ch_tick   (ch_tick),
  .ch_expire (ch_expire),
  .ctl_wr    (ctl_wr),
  .ch_cnt    (ch_cnt),
  .ien       (ien),
  .ist       (ist)
);

// File: tb/test_dual_countdown_timer.sv
`timescale 1ns/1ps
module test_dual_countdown_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dual_countdown_timer i_dual_countdown_timer (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Behavioural reference model, stepped on each rising edge
  logic [31:0] m_cnt [2];
  logic [31:0] m_ival[2];
  int          m_pc  [2];
  int          m_sel [2];
  bit          m_en  [2];
  bit          m_one [2];
  logic [1:0]  m_ie, m_st;
  logic [31:0] m_rdata;
  bit          m_irq;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_ival[c] = 0; m_pc[c] = 0; m_sel[c] = 0; m_en[c] = 0; m_one[c] = 0;
      end
      m_ie = 0; m_st = 0; m_rdata = 0; m_irq = 0;
    end else begin
      logic [31:0] rd;
      logic [1:0]  setb;
      rd = 0;
      setb = 0;
      if (reg_addr == 8'h00) rd = {30'd0, m_ie};
      if (reg_addr == 8'h04) rd = {30'd0, m_st};
      for (int c = 0; c < 2; c++) begin
        if (reg_addr == 8'(16 + 32*c)) rd = {24'd0, m_one[c], 3'(m_sel[c]), 3'b000, m_en[c]};
        if (reg_addr == 8'(20 + 32*c)) rd = m_ival[c];
        if (reg_addr == 8'(28 + 32*c)) rd = m_cnt[c];
      end
      m_irq = |(m_st & m_ie);
      m_rdata = rd;
      for (int c = 0; c < 2; c++) begin
        bit tk;
        tk = m_en[c] && (m_pc[c] == (1 << m_sel[c]) - 1);
        if (!m_en[c] || tk) m_pc[c] = 0; else m_pc[c] = m_pc[c] + 1;
        if (tk) begin
          if (m_cnt[c] == 0) begin
            setb[c] = 1'b1;
            if (m_one[c]) m_en[c] = 0; else m_cnt[c] = m_ival[c];
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (reg_we && reg_addr == 8'(16 + 32*c)) begin
          m_en[c]  = reg_wdata[0];
          m_one[c] = reg_wdata[7];
          m_sel[c] = int'(reg_wdata[6:4]);
          if (reg_wdata[1]) begin m_cnt[c] = m_ival[c]; m_pc[c] = 0; end
        end
        if (reg_we && reg_addr == 8'(20 + 32*c)) m_ival[c] = reg_wdata;
      end
      if (reg_we && reg_addr == 8'h04) m_st = m_st & ~reg_wdata[1:0];
      m_st = m_st | setb;
      if (reg_we && reg_addr == 8'h00) m_ie = reg_wdata[1:0];
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (reg_rdata !== m_rdata) begin
        n_err++;
        $display("FAIL R13 model read data: actual %h expected %h", reg_rdata, m_rdata);
      end
      n_chk++;
      if (irq_out !== m_irq) begin
        n_err++;
        $display("FAIL R9 model interrupt: actual %0b expected %0b", irq_out, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", {31'd0, irq_out}, 0);
    rst = 1'b0;
    // R1: every register reads zero after reset
    rd_chk("R1 ien", 8'h00, 0);
    rd_chk("R1 ist", 8'h04, 0);
    rd_chk("R1 ctrl0", 8'h10, 0);
    rd_chk("R1 ival0", 8'h14, 0);
    rd_chk("R1 cnt0", 8'h1C, 0);
    rd_chk("R1 ctrl1", 8'h30, 0);
    rd_chk("R1 ival1", 8'h34, 0);
    rd_chk("R1 cnt1", 8'h3C, 0);
    chk("R1 irq", {31'd0, irq_out}, 0);
    // R2 / R3: field layout and addresses
    wr(8'h30, 32'hF0);
    rd_chk("R3 ctrl1 readback", 8'h30, 32'hF0);
    wr(8'h34, 32'h12345678);
    rd_chk("R3 ival1 readback", 8'h34, 32'h12345678);
    wr(8'h30, 32'h0);
    wr(8'h10, 32'h72);
    rd_chk("R2 reload reads zero", 8'h10, 32'h70);
    // R11: count is read-only
    wr(8'h14, 40);
    wr(8'h10, 32'h02);
    wr(8'h1C, 32'hDEAD);
    rd_chk("R11 count write ignored", 8'h1C, 40);
    // R4: load and count
    wr(8'h14, 100);
    wr(8'h10, 32'h03);
    rd_chk("R4 loaded", 8'h1C, 100);
    rd_chk("R4 first tick", 8'h1C, 99);
    // R5: prescaler select 2
    wr(8'h14, 50);
    wr(8'h10, 32'h23);
    rd_chk("R5 phase0", 8'h1C, 50);
    rd_chk("R5 phase1", 8'h1C, 50);
    rd_chk("R5 phase2", 8'h1C, 50);
    rd_chk("R5 phase3", 8'h1C, 50);
    rd_chk("R5 tick", 8'h1C, 49);
    // R10: disable freezes
    wr(8'h10, 32'h00);
    rd(8'h1C, a);
    repeat (5) @(negedge clk);
    rd(8'h1C, b);
    chk("R10 frozen count", b, a);
    // R6: periodic wrap
    wr(8'h14, 3);
    wr(8'h10, 32'h03);
    rd_chk("R6 c3", 8'h1C, 3);
    rd_chk("R6 c2", 8'h1C, 2);
    rd_chk("R6 c1", 8'h1C, 1);
    rd_chk("R6 c0", 8'h1C, 0);
    rd_chk("R6 reloaded", 8'h1C, 3);
    rd_chk("R6 status set", 8'h04, 1);
    rd_chk("R6 still enabled", 8'h10, 32'h01);
    wr(8'h10, 32'h00);
    repeat (3) @(negedge clk);
    wr(8'h04, 32'h1);
    rd_chk("R8 cleared", 8'h04, 0);
    // R7: single shot
    wr(8'h14, 5);
    wr(8'h10, 32'h83);
    repeat (20) @(negedge clk);
    rd_chk("R7 enable dropped", 8'h10, 32'h80);
    rd_chk("R7 count at zero", 8'h1C, 0);
    rd_chk("R7 status set", 8'h04, 1);
    // R8 / R9
    wr(8'h04, 32'h0);
    rd_chk("R8 zero write keeps", 8'h04, 1);
    chk("R9 masked", {31'd0, irq_out}, 0);
    wr(8'h00, 32'h1);
    @(negedge clk);
    chk("R9 raised", {31'd0, irq_out}, 1);
    wr(8'h04, 32'h1);
    @(negedge clk);
    chk("R9 dropped", {31'd0, irq_out}, 0);
    rd_chk("R8 one write clears", 8'h04, 0);
    // R12: time base on channel 1
    wr(8'h34, 32'hFFFFFFFF);
    wr(8'h30, 32'h03);
    rd(8'h3C, a);
    rd(8'h3C, b);
    chk("R12 start all ones", a, 32'hFFFFFFFF);
    chk("R12 elapsed step", (~b) - (~a), 1);
    rd_chk("R12 channel0 untouched", 8'h1C, 0);
    rd_chk("R12 no status", 8'h04, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule